// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block keeps one small ready buffer for each operation class and, on every clock, picks up to `W` instructions to send to execution. Each buffer holds sequence-numbered entries, and the entry with the smallest sequence number that has not been sent is that class's head. On each cycle the classes are ranked by the age of their heads, oldest first. Each class is then tested for a free execution unit. The first `W` classes that have a unit available are granted. A class whose unit is busy is skipped and counts a busy event, but only if the walk reached it before the issue width ran out.

A squash request marks every stored entry younger than a given sequence number. A marked head is discarded on the next selection and does not use issue width. A non-memory instruction frees its slot when it is granted. A memory instruction keeps its slot until a completion carrying its sequence number arrives. Classes that a parameter marks as needing no execution unit always issue when their turn comes. Grants, busy pulses, per-class busy counters and the per-cycle issue count are all registered.

Top module: `isel_top`

## Requirements
- R1: Grants in one cycle go to different classes in increasing order of their head sequence numbers. Slot 0 holds the oldest grant, and the valid slots are contiguous from slot 0.
- R2: No more than `W` grants are made in a cycle. Any remaining classes are not visited that cycle.
- R3: A squash with sequence `S` marks every stored entry with sequence greater than `S`. A marked head is removed at the next selection without issuing, and it does not consume a slot of width.
- R4: A visited class with a ready head whose execution unit is not free (`fu_free[c]`=0) is skipped. It raises `busy_evt[c]` for one cycle and adds one to its busy counter. A class not visited because the width is used up reports nothing.
- R5: Within a class the head is always the unsent entry with the smallest sequence number, whatever the insert order. After a class issues, it is ranked by its new head.
- R6: A granted non-memory entry frees its slot at once. A granted memory entry (`ins_mem`=1) holds its slot until `done_en` arrives with its sequence number.
- R7: A class whose bit is set in `NO_UNIT` (default: class 3 only) issues when visited, regardless of `fu_free`.
- R8: A class issues at most one instruction per cycle.
- R9: An insert becomes eligible at the selection one clock after it is captured. An insert into a class whose `D` slots are all held is ignored.
- R10: The grant, busy and count outputs show the decision made at a clock edge right after that edge. `issue_cnt` equals the number of valid grant slots.
- R11: After reset, no grant is valid, `issue_cnt` is 0, and all busy counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert one ready instruction |
| ins_cls | input | $clog2(K) | Class of the inserted instruction |
| ins_seq | input | SW | Sequence number of the inserted instruction |
| ins_mem | input | 1 | Inserted instruction is a memory access |
| sq_en | input | 1 | Squash request |
| sq_seq | input | SW | Entries younger than this are squashed |
| done_en | input | 1 | Memory completion |
| done_seq | input | SW | Sequence number of the completed memory access |
| fu_free | input | K | One bit per class: an execution unit is available |
| gnt_vld | output | W | Valid bit per grant slot |
| gnt_cls | output | W*$clog2(K) | Class per grant slot, slot w at bits w*$clog2(K) upward |
| gnt_seq | output | W*SW | Sequence number per grant slot, slot w at bits w*SW upward |
| busy_evt | output | K | Busy event per class in the last decision |
| busy_cnt | output | K*CNTW | Running busy counter per class, class c at bits c*CNTW upward |
| issue_cnt | output | $clog2(W+1) | Number of grants in the last decision |

## Verification
An insert captured at edge t first competes at edge t+1, and its grant is visible after that edge. A grant, busy pulse or count caused by `fu_free` applied before edge t is therefore readable at the falling edge that follows t. The bench drives every input on a falling edge and pushes the grants it expects into a scoreboard queue before the edge that makes them. A monitor compares each valid slot at each falling edge. Count and busy checks are read at the falling edge right after the one decision they belong to. Busy counters are checked as differences from a value taken just before that decision.

// File: rtl/isel_pkg.sv
package isel_pkg;
    // flags carried by one buffered instruction
    typedef struct packed {
        logic vld;   // slot occupied
        logic sent;  // granted, waiting for memory completion
        logic kill;  // squashed
        logic mem;   // memory access
    } slot_flag_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/age_queue.sv
module age_queue
    import isel_pkg::*;
#(
    parameter int D  = 4,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  logic [SW-1:0] ins_seq,
    input  logic          ins_mem,
    input  logic          sq_en,
    input  logic [SW-1:0] sq_seq,
    input  logic          done_en,
    input  logic [SW-1:0] done_seq,
    input  logic          pop_i,
    input  logic          drop_i,
    output logic          head_vld,
    output logic          head_kill,
    output logic [SW-1:0] head_seq
);
    localparam int IW = width_of(D);

    typedef struct packed {
        slot_flag_t [D-1:0]         fl;
        logic       [D-1:0][SW-1:0] seq;
    } buf_t;

    buf_t buf_q, buf_d;
    logic          hfound, ffound;
    logic [IW-1:0] hidx, fidx;

    // head: oldest unsent entry; free: lowest empty slot
    always_comb begin
        hfound = 1'b0;
        hidx   = '0;
        ffound = 1'b0;
        fidx   = '0;
        for (int i = 0; i < D; i++) begin
            if (buf_q.fl[i].vld && !buf_q.fl[i].sent &&
                (!hfound || buf_q.seq[i] < buf_q.seq[hidx])) begin
                hfound = 1'b1;
                hidx   = IW'(i);
            end
            if (!buf_q.fl[i].vld && !ffound) begin
                ffound = 1'b1;
                fidx   = IW'(i);
            end
        end
    end

    assign head_vld  = hfound;
    assign head_kill = buf_q.fl[hidx].kill;
    assign head_seq  = buf_q.seq[hidx];

    always_comb begin
        buf_d = buf_q;
        if (pop_i) begin
            if (buf_q.fl[hidx].mem) buf_d.fl[hidx].sent = 1'b1;
            else                    buf_d.fl[hidx].vld  = 1'b0;
        end
        if (drop_i) buf_d.fl[hidx].vld = 1'b0;
        for (int i = 0; i < D; i++) begin
            if (sq_en && buf_q.fl[i].vld && buf_q.seq[i] > sq_seq)
                buf_d.fl[i].kill = 1'b1;
            if (done_en && buf_q.fl[i].vld && buf_q.fl[i].sent &&
                buf_q.seq[i] == done_seq)
                buf_d.fl[i].vld = 1'b0;
        end
        if (ins_en && ffound) begin
            buf_d.fl[fidx]  = '{vld: 1'b1, sent: 1'b0, kill: 1'b0, mem: ins_mem};
            buf_d.seq[fidx] = ins_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    // R3
    pop_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && drop_i));
    // R6
    pop_live_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (head_vld && !head_kill));
endmodule

// File: rtl/issue_pick.sv
module issue_pick
    import isel_pkg::*;
#(
    parameter int K  = 4,
    parameter int W  = 2,
    parameter int SW = 8,
    parameter int CLW = 2
) (
    input  logic [K-1:0]           head_vld,
    input  logic [K-1:0]           head_kill,
    input  logic [K-1:0][SW-1:0]   head_seq,
    input  logic [K-1:0]           fu_ok,
    output logic [K-1:0]           pop,
    output logic [K-1:0]           drop,
    output logic [K-1:0]           busy,
    output logic [W-1:0]           slot_vld,
    output logic [W-1:0][CLW-1:0]  slot_cls,
    output logic [W-1:0][SW-1:0]   slot_seq
);
    logic [K-1:0] cand, elig;

    assign cand = head_vld & ~head_kill;
    assign elig = cand & fu_ok;
    assign drop = head_vld & head_kill;

    // rank of a class = eligible classes with an older head
    always_comb begin
        pop      = '0;
        busy     = '0;
        slot_vld = '0;
        slot_cls = '0;
        slot_seq = '0;
        for (int c = 0; c < K; c++) begin
            int older;
            older = 0;
            for (int j = 0; j < K; j++) begin
                if (j != c && elig[j] &&
                    (head_seq[j] < head_seq[c] ||
                     (head_seq[j] == head_seq[c] && j < c)))
                    older++;
            end
            if (older < W) begin
                pop[c]  = elig[c];
                busy[c] = cand[c] && !fu_ok[c];
                for (int w = 0; w < W; w++) begin
                    if (elig[c] && w == older) begin
                        slot_vld[w] = 1'b1;
                        slot_cls[w] = CLW'(c);
                        slot_seq[w] = head_seq[c];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/isel_top.sv
module isel_top
    import isel_pkg::*;
#(
    parameter int K    = 4,
    parameter int D    = 4,
    parameter int W    = 2,
    parameter int SW   = 8,
    parameter int CNTW = 8,
    parameter logic [K-1:0] NO_UNIT = 4'b1000,
    localparam int CLW = width_of(K),
    localparam int NW  = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic [CLW-1:0]    ins_cls,
    input  logic [SW-1:0]     ins_seq,
    input  logic              ins_mem,
    input  logic              sq_en,
    input  logic [SW-1:0]     sq_seq,
    input  logic              done_en,
    input  logic [SW-1:0]     done_seq,
    input  logic [K-1:0]      fu_free,
    output logic [W-1:0]      gnt_vld,
    output logic [W*CLW-1:0]  gnt_cls,
    output logic [W*SW-1:0]   gnt_seq,
    output logic [K-1:0]      busy_evt,
    output logic [K*CNTW-1:0] busy_cnt,
    output logic [NW-1:0]     issue_cnt
);
    typedef struct packed {
        logic [W-1:0]           gv;
        logic [W-1:0][CLW-1:0]  gc;
        logic [W-1:0][SW-1:0]   gs;
        logic [K-1:0]           be;
        logic [K-1:0][CNTW-1:0] bc;
        logic [NW-1:0]          n;
    } out_t;

    out_t st_q, st_d;

    logic [K-1:0]          hv, hk, pop, drop, busy;
    logic [K-1:0][SW-1:0]  hs;
    logic [W-1:0]          sv;
    logic [W-1:0][CLW-1:0] sc;
    logic [W-1:0][SW-1:0]  ss;

    for (genvar c = 0; c < K; c++) begin : g_cls
        age_queue #(.D(D), .SW(SW)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .ins_en   (ins_en && ins_cls == CLW'(c)),
            .ins_seq  (ins_seq),
            .ins_mem  (ins_mem),
            .sq_en    (sq_en),
            .sq_seq   (sq_seq),
            .done_en  (done_en),
            .done_seq (done_seq),
            .pop_i    (pop[c]),
            .drop_i   (drop[c]),
            .head_vld (hv[c]),
            .head_kill(hk[c]),
            .head_seq (hs[c])
        );
    end

    issue_pick #(.K(K), .W(W), .SW(SW), .CLW(CLW)) u_pick (
        .head_vld (hv),
        .head_kill(hk),
        .head_seq (hs),
        .fu_ok    (fu_free | NO_UNIT),
        .pop      (pop),
        .drop     (drop),
        .busy     (busy),
        .slot_vld (sv),
        .slot_cls (sc),
        .slot_seq (ss)
    );

    always_comb begin
        st_d    = st_q;
        st_d.gv = sv;
        st_d.gc = sc;
        st_d.gs = ss;
        st_d.be = busy;
        st_d.n  = NW'($countones(pop));
        for (int c = 0; c < K; c++)
            st_d.bc[c] = st_q.bc[c] + CNTW'(busy[c]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_vld   = st_q.gv;
    assign gnt_cls   = st_q.gc;
    assign gnt_seq   = st_q.gs;
    assign busy_evt  = st_q.be;
    assign busy_cnt  = st_q.bc;
    assign issue_cnt = st_q.n;

    // R2
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.n <= NW'(W));
    // R10
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.n) == $countones(st_q.gv));

    for (genvar w = 0; w + 1 < W; w++) begin : g_ord
        // R1
        age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.gv[w+1] |-> (st_q.gv[w] && st_q.gs[w] < st_q.gs[w+1]));
    end

    for (genvar a = 0; a < W; a++) begin : g_da
        for (genvar b = a + 1; b < W; b++) begin : g_db
            // R8
            one_per_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.gv[a] && st_q.gv[b]) |-> st_q.gc[a] != st_q.gc[b]);
        end
    end
endmodule

// File: tb/sim_isel_top.sv
module sim_isel_top;
    localparam int CLK_NS = 10;
    localparam int K = 4, D = 4, W = 2, SW = 8, CNTW = 8;
    localparam int CLW = 2, NW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_en = 0, ins_mem = 0, sq_en = 0, done_en = 0;
    logic [CLW-1:0] ins_cls = '0;
    logic [SW-1:0]  ins_seq = '0, sq_seq = '0, done_seq = '0;
    logic [K-1:0]   fu_free = '0;
    logic [W-1:0]      gnt_vld;
    logic [W*CLW-1:0]  gnt_cls;
    logic [W*SW-1:0]   gnt_seq;
    logic [K-1:0]      busy_evt;
    logic [K*CNTW-1:0] busy_cnt;
    logic [NW-1:0]     issue_cnt;

    always #(CLK_NS/2) clk = ~clk;

    isel_top #(.K(K), .D(D), .W(W), .SW(SW), .CNTW(CNTW)) u0 (
        .clk, .rst_n, .ins_en, .ins_cls, .ins_seq, .ins_mem, .sq_en, .sq_seq,
        .done_en, .done_seq, .fu_free, .gnt_vld, .gnt_cls, .gnt_seq,
        .busy_evt, .busy_cnt, .issue_cnt);

    typedef struct { int cls; int seq; string req; } exp_t;
    exp_t expq[$];
    int checks = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic want(input int c, input int s, input string req);
        exp_t e;
        e.cls = c; e.seq = s; e.req = req;
        expq.push_back(e);
    endtask

    function automatic int bcnt(input int c);
        return int'(busy_cnt[c*CNTW +: CNTW]);
    endfunction

    // monitor: compare every valid grant slot against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int w = 0; w < W; w++) begin
                if (gnt_vld[w]) begin
                    if (expq.size() == 0) begin
                        checks++; bad++;
                        $display("FAIL R1 unexpected grant act=%0d/%0d exp=none",
                                 gnt_cls[w*CLW +: CLW], gnt_seq[w*SW +: SW]);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk({e.req, " class"}, int'(gnt_cls[w*CLW +: CLW]), e.cls);
                        chk({e.req, " seq"}, int'(gnt_seq[w*SW +: SW]), e.seq);
                    end
                end
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic ins(input int c, input int s, input bit m);
        ins_en = 1; ins_cls = CLW'(c); ins_seq = SW'(s); ins_mem = m;
        tick();
        ins_en = 0; ins_mem = 0;
    endtask

    task automatic pulse(input logic [K-1:0] m);
        fu_free = m;
        tick();
        fu_free = '0;
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        checks++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        summary();
    end

    initial begin
        int b0, b1, b2;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk("R11 gnt_vld", int'(gnt_vld), 0);
        chk("R11 issue_cnt", int'(issue_cnt), 0);
        chk("R11 busy_cnt", int'(busy_cnt != '0), 0);

        // R1 R2 R5: cross-class age order, width cap, re-rank
        ins(0, 10, 0); ins(0, 5, 0); ins(1, 7, 0); ins(2, 3, 0); ins(2, 20, 0);
        want(2, 3, "R1"); want(0, 5, "R5");
        pulse(4'b0111);
        chk("R2 width cap", int'(issue_cnt), 2);
        want(1, 7, "R5"); want(0, 10, "R5");
        pulse(4'b0111);
        want(2, 20, "R1");
        pulse(4'b0111);
        chk("R10 count one", int'(issue_cnt), 1);

        // R4: busy class skipped, younger free class issues
        ins(0, 30, 0); ins(1, 40, 0);
        b0 = bcnt(0); b1 = bcnt(1);
        want(1, 40, "R4");
        pulse(4'b0010);
        chk("R4 busy_evt", int'(busy_evt), 1);
        chk("R4 cnt c0", (bcnt(0) - b0) & 8'hff, 1);
        chk("R4 cnt c1", (bcnt(1) - b1) & 8'hff, 0);
        want(0, 30, "R4");
        pulse(4'b0001);

        // R4 R2: class beyond width not visited, no busy event
        ins(0, 50, 0); ins(1, 51, 0); ins(2, 52, 0);
        b2 = bcnt(2);
        want(0, 50, "R2"); want(1, 51, "R2");
        pulse(4'b0011);
        chk("R4 no busy past width", int'(busy_evt), 0);
        chk("R4 cnt c2 unchanged", (bcnt(2) - b2) & 8'hff, 0);
        want(2, 52, "R2");
        pulse(4'b0100);

        // R3: squashed head removed without using width
        ins(1, 81, 0); ins(2, 82, 0); ins(0, 85, 0);
        sq_en = 1; sq_seq = 8'd84; tick(); sq_en = 0;
        want(1, 81, "R3"); want(2, 82, "R3");
        pulse(4'b0111);
        chk("R3 width kept", int'(issue_cnt), 2);
        pulse(4'b0111);
        chk("R3 squashed not issued", int'(issue_cnt), 0);
        ins(0, 86, 0);
        want(0, 86, "R3");
        pulse(4'b0001);

        // R6 R9: memory entry holds its slot until completion
        ins(0, 90, 1); ins(0, 95, 0);
        want(0, 90, "R6");
        pulse(4'b0001);
        want(0, 95, "R6");
        pulse(4'b0001);
        ins(0, 100, 0); ins(0, 101, 0); ins(0, 102, 0);
        ins(0, 103, 0); // full: ignored
        done_en = 1; done_seq = 8'd90; tick(); done_en = 0;
        ins(0, 104, 0);
        want(0, 100, "R6"); want(0, 101, "R6"); want(0, 102, "R6"); want(0, 104, "R9");
        fu_free = 4'b0001;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8 one per class", int'(issue_cnt), 1);
        end
        tick();
        chk("R9 full insert dropped", int'(issue_cnt), 0);
        fu_free = '0;

        // R7: no-unit class issues with every unit busy
        want(3, 110, "R7");
        ins(3, 110, 0);
        tick();
        chk("R7 count", int'(issue_cnt), 1);

        // R8: two ready in one class, one per cycle
        ins(1, 120, 0); ins(1, 121, 0);
        want(1, 120, "R8");
        pulse(4'b0010);
        chk("R8 single", int'(issue_cnt), 1);
        want(1, 121, "R8");
        pulse(4'b0010);

        repeat (3) tick();
        chk("R1 scoreboard drained", expq.size(), 0);
        summary();
    end
endmodule